// File: doc/BRIEF.md
# Hardware Sprite Line Engine

This block draws one sprite, sixteen pixels wide with two bits per pixel, on a raster display. It holds a horizontal position, a first and last display line, and two 16-bit bit planes. A comparator watches the incoming horizontal beam counter. When the counter reaches the stored position and the sprite is armed, the planes shift out one pixel per clock as a 2-bit colour index with a valid flag. A zero code is transparent.

The registers can be written directly over a small CPU write port. They can also be filled by the block's own fetch sequencer, which walks a word list in memory over a request/acknowledge port. A list holds, in order, a position pair followed by one pair of plane words for each displayed line. After the last line of one window, the sequencer reads the next position pair, so the same sprite can appear again lower in the frame. A pair of zero words ends the list for that frame.

Top module: `sprite_line_engine`

## Requirements
- R1: Pixel k (k = 0 first, 15 last) takes bit 15-k of plane B (register select 4) as its high index bit and bit 15-k of plane A (select 3) as its low bit.
- R2: A pixel code of 00 gives pix_valid low and pix_idx 00. Codes 01, 10 and 11 give pix_valid high with pix_idx equal to the code.
- R3: Pixel k is presented in the clock cycle that follows the cycle in which beam_h equals the horizontal position plus k. After 16 pixels the output returns to idle.
- R4: With list fetching off, a CPU write to plane A arms the sprite. An armed sprite is shown again on every following line where beam_h matches the horizontal position.
- R5: A CPU write to the horizontal position (select 0) disarms the sprite. It then shows nothing until plane A is written again.
- R6: After one copy has been shifted out, the CPU can rewrite the position and plane A to show a second copy later on the same line.
- R7: When beam_v and beam_h are both 0 and list fetching is enabled (select 6 bit 0), the sequencer restarts at the list base (select 5) and reads a position pair. The first word is {first line[7:0], horizontal position[7:0]}. The second word is {end line[7:0], any low byte}.
- R8: The sprite is shown only on lines v with first line <= v < end line. On each such line a pair of plane words is read when beam_h is 0: first plane B, then plane A, and the plane A load arms the sprite. Lines outside the window show nothing.
- R9: On the end line the sequencer reads the next position pair from the following addresses. A later window in the same frame is then displayed.
- R10: A position pair of two zero words stops all fetch requests until the next frame start.
- R11: fetch_req stays high with fetch_addr stable until fetch_ack is seen. Each acknowledged word advances the address by one.
- R12: During and right after reset, pix_valid, pix_idx and fetch_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beam_h | input | HW (8) | Horizontal beam counter |
| beam_v | input | VW (8) | Vertical beam counter |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_sel | input | 3 | Register select: 0 position, 1 first line, 2 end line, 3 plane A, 4 plane B, 5 list base, 6 control |
| cpu_wdata | input | 16 | CPU write data |
| fetch_req | output | 1 | Memory word request |
| fetch_addr | output | AW (16) | Word address of the request |
| fetch_ack | input | 1 | Request accepted, fetch_data valid |
| fetch_data | input | 16 | Word returned from memory |
| pix_valid | output | 1 | Non-transparent pixel present |
| pix_idx | output | 2 | Colour index of the pixel |

## Verification
The CPU-driven patterns use plane words that mix all four codes, including runs of transparent pixels inside the sprite. These patterns separate bit ordering and plane assignment errors from transparency errors. A second copy on one line, and a disarm followed by silent lines, show whether arming follows the position and plane A writes rather than the line. A memory list with two windows and a terminator, run with a delayed acknowledge, shows the window bounds, the vertical reuse, the end-of-list stop and the fetch address sequence. The word count and the address order tell a sequencer that over-fetches apart from one that misplaces a word.

// File: rtl/sle_pkg.sv
package sle_pkg;
  // CPU register select codes
  typedef enum logic [2:0] {
    SEL_HPOS   = 3'd0,
    SEL_VFIRST = 3'd1,
    SEL_VEND   = 3'd2,
    SEL_PLANEA = 3'd3,
    SEL_PLANEB = 3'd4,
    SEL_BASE   = 3'd5,
    SEL_CTRL   = 3'd6
  } reg_sel_e;

  // List sequencer states
  typedef enum logic [1:0] {
    DS_OFF,
    DS_POS,
    DS_WIN,
    DS_END
  } dma_state_e;
endpackage

// File: rtl/sle_dma.sv
module sle_dma
  import sle_pkg::*;
#(
  parameter int HW = 8,
  parameter int VW = 8,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_on,
  input  logic [AW-1:0] list_base,
  input  logic [HW-1:0] beam_h,
  input  logic [VW-1:0] beam_v,
  input  logic [VW-1:0] vfirst,
  input  logic [VW-1:0] vend,
  input  logic          fetch_ack,
  input  logic [DW-1:0] fetch_data,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  output logic          pos_ld,
  output logic [HW-1:0] pos_h,
  output logic [VW-1:0] pos_vfirst,
  output logic [VW-1:0] pos_vend,
  output logic          planeb_ld,
  output logic          planea_ld,
  output logic          line_clr
);
  localparam int FW = DW / 2;   // byte field inside a position word

  dma_state_e    st_q, st_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [1:0]    wc_q, wc_d;     // words left in current pair
  logic          ispos_q, ispos_d;
  logic [DW-1:0] w0_q;
  logic          w0_en;
  logic          ln_go, frm_go, take;

  assign ln_go  = (beam_h == '0);
  assign frm_go = ln_go && (beam_v == '0);
  assign take   = (wc_q != 2'd0) && fetch_ack;

  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    wc_d      = wc_q;
    ispos_d   = ispos_q;
    w0_en     = 1'b0;
    pos_ld    = 1'b0;
    planeb_ld = 1'b0;
    planea_ld = 1'b0;
    if (!dma_on) begin
      st_d = DS_OFF;
      wc_d = 2'd0;
    end else begin
      if (take) begin
        ptr_d = ptr_q + 1'b1;
        wc_d  = wc_q - 1'b1;
        if (ispos_q) begin
          if (wc_q == 2'd2) begin
            w0_en = 1'b1;
          end else if ((w0_q == '0) && (fetch_data == '0)) begin
            st_d = DS_END;
          end else begin
            pos_ld = 1'b1;
            st_d   = DS_WIN;
          end
        end else if (wc_q == 2'd2) begin
          planeb_ld = 1'b1;
        end else begin
          planea_ld = 1'b1;
        end
      end
      if (frm_go) begin
        ptr_d   = list_base;
        wc_d    = 2'd2;
        ispos_d = 1'b1;
        st_d    = DS_POS;
      end else if (ln_go && (st_q == DS_WIN) && (wc_q == 2'd0)) begin
        if (beam_v >= vend) begin
          wc_d    = 2'd2;
          ispos_d = 1'b1;
          st_d    = DS_POS;
        end else if (beam_v >= vfirst) begin
          wc_d    = 2'd2;
          ispos_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= DS_OFF;
      ptr_q   <= '0;
      wc_q    <= 2'd0;
      ispos_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      wc_q    <= wc_d;
      ispos_q <= ispos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q <= '0;
    end else if (w0_en) begin
      w0_q <= fetch_data;
    end
  end

  assign fetch_req  = dma_on && (wc_q != 2'd0);
  assign fetch_addr = ptr_q;
  assign pos_h      = w0_q[HW-1:0];
  assign pos_vfirst = w0_q[FW +: VW];
  assign pos_vend   = fetch_data[FW +: VW];
  assign line_clr   = dma_on && ln_go;
endmodule

// File: rtl/sle_regs.sv
module sle_regs
  import sle_pkg::*;
#(
  parameter int HW = 8,
  parameter int VW = 8,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we,
  input  logic [2:0]    cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          pos_ld,
  input  logic [HW-1:0] pos_h,
  input  logic [VW-1:0] pos_vfirst,
  input  logic [VW-1:0] pos_vend,
  input  logic          planeb_ld,
  input  logic          planea_ld,
  input  logic [DW-1:0] fetch_data,
  input  logic          line_clr,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vfirst,
  output logic [VW-1:0] vend,
  output logic [DW-1:0] plane_a,
  output logic [DW-1:0] plane_b,
  output logic [AW-1:0] list_base,
  output logic          dma_on,
  output logic          armed
);
  logic wr_h, wr_vf, wr_ve, wr_a, wr_b, wr_base, wr_ctl;
  logic h_en, vf_en, ve_en, a_en, b_en;
  logic [HW-1:0] h_d;
  logic [VW-1:0] vf_d, ve_d;
  logic [DW-1:0] a_d, b_d;
  logic armed_d;

  assign wr_h    = cpu_we && (cpu_sel == SEL_HPOS);
  assign wr_vf   = cpu_we && (cpu_sel == SEL_VFIRST);
  assign wr_ve   = cpu_we && (cpu_sel == SEL_VEND);
  assign wr_a    = cpu_we && (cpu_sel == SEL_PLANEA);
  assign wr_b    = cpu_we && (cpu_sel == SEL_PLANEB);
  assign wr_base = cpu_we && (cpu_sel == SEL_BASE);
  assign wr_ctl  = cpu_we && (cpu_sel == SEL_CTRL);

  // CPU writes take priority over list loads of the same register
  always_comb begin
    h_en  = wr_h  || pos_ld;
    vf_en = wr_vf || pos_ld;
    ve_en = wr_ve || pos_ld;
    a_en  = wr_a  || planea_ld;
    b_en  = wr_b  || planeb_ld;
    h_d   = wr_h  ? cpu_wdata[HW-1:0] : pos_h;
    vf_d  = wr_vf ? cpu_wdata[VW-1:0] : pos_vfirst;
    ve_d  = wr_ve ? cpu_wdata[VW-1:0] : pos_vend;
    a_d   = wr_a  ? cpu_wdata : fetch_data;
    b_d   = wr_b  ? cpu_wdata : fetch_data;
    if (wr_h)                     armed_d = 1'b0;
    else if (wr_a || planea_ld)   armed_d = 1'b1;
    else if (line_clr)            armed_d = 1'b0;
    else                          armed_d = armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hpos <= '0;
    else if (h_en) hpos <= h_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vfirst <= '0;
    else if (vf_en) vfirst <= vf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vend <= '0;
    else if (ve_en) vend <= ve_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) plane_a <= '0;
    else if (a_en) plane_a <= a_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) plane_b <= '0;
    else if (b_en) plane_b <= b_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) list_base <= '0;
    else if (wr_base) list_base <= cpu_wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_on <= 1'b0;
    else if (wr_ctl) dma_on <= cpu_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else armed <= armed_d;
  end
endmodule

// File: rtl/sle_shifter.sv
module sle_shifter #(
  parameter int HW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] beam_h,
  input  logic [HW-1:0] hpos,
  input  logic          armed,
  input  logic [DW-1:0] plane_a,
  input  logic [DW-1:0] plane_b,
  output logic          pix_valid,
  output logic [1:0]    pix_idx
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sa_q, sa_d, sb_q, sb_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit, run, sh_en;
  logic [1:0]    code;

  assign hit   = armed && (beam_h == hpos);
  assign run   = (cnt_q != '0);
  assign sh_en = hit || run;

  always_comb begin
    sa_d  = sa_q;
    sb_d  = sb_q;
    cnt_d = cnt_q;
    if (hit) begin
      sa_d  = plane_a;
      sb_d  = plane_b;
      cnt_d = CW'(DW);
    end else if (run) begin
      sa_d  = {sa_q[DW-2:0], 1'b0};
      sb_d  = {sb_q[DW-2:0], 1'b0};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q  <= '0;
      sb_q  <= '0;
      cnt_q <= '0;
    end else if (sh_en) begin
      sa_q  <= sa_d;
      sb_q  <= sb_d;
      cnt_q <= cnt_d;
    end
  end

  assign code      = run ? {sb_q[DW-1], sa_q[DW-1]} : 2'b00;
  assign pix_valid = (code != 2'b00);
  assign pix_idx   = code;
endmodule

// File: rtl/sprite_line_engine.sv
module sprite_line_engine #(
  parameter int HW = 8,
  parameter int VW = 8,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] beam_h,
  input  logic [VW-1:0] beam_v,
  input  logic          cpu_we,
  input  logic [2:0]    cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_ack,
  input  logic [DW-1:0] fetch_data,
  output logic          pix_valid,
  output logic [1:0]    pix_idx
);
  logic          pos_ld, planeb_ld, planea_ld, line_clr;
  logic [HW-1:0] pos_h, hpos_q;
  logic [VW-1:0] pos_vfirst, pos_vend, vfirst_q, vend_q;
  logic [DW-1:0] plane_a_q, plane_b_q;
  logic [AW-1:0] list_base_q;
  logic          dma_on_q, armed_q;

  sle_regs #(.HW(HW), .VW(VW), .AW(AW), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .pos_ld(pos_ld), .pos_h(pos_h), .pos_vfirst(pos_vfirst), .pos_vend(pos_vend),
    .planeb_ld(planeb_ld), .planea_ld(planea_ld), .fetch_data(fetch_data),
    .line_clr(line_clr),
    .hpos(hpos_q), .vfirst(vfirst_q), .vend(vend_q),
    .plane_a(plane_a_q), .plane_b(plane_b_q),
    .list_base(list_base_q), .dma_on(dma_on_q), .armed(armed_q)
  );

  sle_dma #(.HW(HW), .VW(VW), .AW(AW), .DW(DW)) dma_i (
    .clk(clk), .rst_n(rst_n),
    .dma_on(dma_on_q), .list_base(list_base_q),
    .beam_h(beam_h), .beam_v(beam_v),
    .vfirst(vfirst_q), .vend(vend_q),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .pos_ld(pos_ld), .pos_h(pos_h), .pos_vfirst(pos_vfirst), .pos_vend(pos_vend),
    .planeb_ld(planeb_ld), .planea_ld(planea_ld), .line_clr(line_clr)
  );

  sle_shifter #(.HW(HW), .DW(DW)) shf_i (
    .clk(clk), .rst_n(rst_n),
    .beam_h(beam_h), .hpos(hpos_q), .armed(armed_q),
    .plane_a(plane_a_q), .plane_b(plane_b_q),
    .pix_valid(pix_valid), .pix_idx(pix_idx)
  );
endmodule

// File: rtl/sle_checker.sv
module sle_checker #(
  parameter int HW = 8,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] beam_h,
  input logic [HW-1:0] hpos,
  input logic          cpu_we,
  input logic [2:0]    cpu_sel,
  input logic          fetch_req,
  input logic          fetch_ack,
  input logic [AW-1:0] fetch_addr,
  input logic          pix_valid,
  input logic [1:0]    pix_idx
);
  logic [HW-1:0] bh_d;
  logic [HW-1:0] offs;
  logic          dis_q;
  logic [4:0]    quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bh_d <= '0;
    else bh_d <= beam_h;
  end
  assign offs = bh_d - hpos;

  // disarm tracker: set by a position write, cleared by any re-arm path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q   <= 1'b0;
      quiet_q <= '0;
    end else if (cpu_we && cpu_sel == 3'd0) begin
      dis_q   <= 1'b1;
      quiet_q <= '0;
    end else if ((cpu_we && cpu_sel == 3'd3) || fetch_ack) begin
      dis_q   <= 1'b0;
    end else if (dis_q && quiet_q != 5'd18) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr));

  a_r11_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && fetch_ack && beam_h != '0 |=>
      !fetch_req || fetch_addr == $past(fetch_addr) + 1'b1);

  a_r2_valid_code: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> pix_idx != 2'b00);

  a_r3_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> offs < HW'(DW));

  a_r5_disarm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q && quiet_q == 5'd18 |-> !pix_valid);
endmodule

bind sprite_line_engine sle_checker #(.HW(HW), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .beam_h(beam_h), .hpos(hpos_q),
  .cpu_we(cpu_we), .cpu_sel(cpu_sel),
  .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_addr(fetch_addr),
  .pix_valid(pix_valid), .pix_idx(pix_idx)
);

// File: tb/sprite_line_engine_tb_top.sv
module sprite_line_engine_tb_top;
  localparam int HT = 96;
  localparam int VT = 24;

  logic        clk, rst_n;
  logic [7:0]  beam_h, beam_v;
  logic        cpu_we;
  logic [2:0]  cpu_sel;
  logic [15:0] cpu_wdata;
  logic        fetch_req, fetch_ack;
  logic [15:0] fetch_addr, fetch_data;
  logic        pix_valid;
  logic [1:0]  pix_idx;

  int checks, errors, idle_bad, acks;
  logic [15:0] mem [0:255];
  logic [15:0] addr_log [$];

  typedef struct { int v; int h; int idx; string tag; } exp_t;
  exp_t q [$];

  sprite_line_engine dut_i (
    .clk(clk), .rst_n(rst_n), .beam_h(beam_h), .beam_v(beam_v),
    .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .pix_valid(pix_valid), .pix_idx(pix_idx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver side: expected pixels of one line
  task automatic push_line(input int v, input int hs, input logic [15:0] a,
                           input logic [15:0] b, input string tag);
    for (int k = 0; k < 16; k++) begin
      exp_t e;
      e.v = v; e.h = hs + k; e.idx = {b[15-k], a[15-k]}; e.tag = tag;
      if (e.idx != 0) q.push_back(e);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cpu_we = 1'b0;
    if (beam_h == 8'(HT - 1)) begin
      beam_h = '0;
      beam_v = (beam_v == 8'(VT - 1)) ? 8'd0 : beam_v + 8'd1;
    end else begin
      beam_h = beam_h + 8'd1;
    end
  endtask

  task automatic go_to(input int v, input int h);
    tick();
    while (!(beam_v == 8'(v) && beam_h == 8'(h))) tick();
  endtask

  task automatic cpu_wr(input logic [2:0] sel, input logic [15:0] d);
    cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = d;
    tick();
  endtask

  // memory model: acknowledge one cycle after a request, then idle one cycle
  initial begin
    fetch_ack = 1'b0; fetch_data = '0;
    forever begin
      @(negedge clk);
      if (fetch_ack) begin
        fetch_ack = 1'b0;
      end else if (fetch_req) begin
        fetch_ack  = 1'b1;
        fetch_data = mem[fetch_addr[7:0]];
        addr_log.push_back(fetch_addr);
        acks++;
      end
    end
  end

  // monitor: compare each produced pixel with the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (pix_valid) begin
          if (q.size() == 0) begin
            check(1'b0, "R5 unexpected pixel h", int'(beam_h), -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.v != int'(beam_v) || e.h != int'(beam_h) || e.idx != int'(pix_idx)) begin
              errors++;
              $display("FAIL %s: pixel v=%0d h=%0d idx=%0d, expected v=%0d h=%0d idx=%0d",
                       e.tag, beam_v, beam_h, pix_idx, e.v, e.h, e.idx);
            end
          end
        end else if (pix_idx != 2'b00) begin
          idle_bad++;
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    checks = 0; errors = 0; idle_bad = 0; acks = 0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_n = 1'b0; beam_h = '0; beam_v = '0;
    cpu_we = 1'b0; cpu_sel = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(pix_valid == 1'b0, "R12 pix_valid", int'(pix_valid), 0);
    check(pix_idx == 2'b00, "R12 pix_idx", int'(pix_idx), 0);
    check(fetch_req == 1'b0, "R12 fetch_req", int'(fetch_req), 0);
    rst_n = 1'b1;
    tick();
    check(fetch_req == 1'b0 && pix_valid == 1'b0, "R12 after release", int'(fetch_req), 0);

    // Manual arming, mixed codes, disarm (R1 R2 R3 R4 R5)
    push_line(3, 30, 16'hA0F3, 16'h0C55, "R3");
    push_line(4, 30, 16'hA0F3, 16'h0C55, "R4");
    push_line(5, 30, 16'hA0F3, 16'h0C55, "R2");
    go_to(2, 40);
    cpu_wr(3'd0, 16'd30);
    cpu_wr(3'd4, 16'h0C55);
    cpu_wr(3'd3, 16'hA0F3);
    go_to(5, 60);
    cpu_wr(3'd0, 16'd50);        // disarm: lines 6..8 stay empty
    go_to(8, 80);
    check(q.size() == 0, "R5 queue after disarm", q.size(), 0);

    // Horizontal reuse (R6) and bit order (R1)
    push_line(9, 20, 16'h8001, 16'h0001, "R1");
    push_line(9, 60, 16'h0000, 16'hFFFF, "R6");
    push_line(10, 60, 16'h0000, 16'hFFFF, "R4");
    go_to(9, 2);
    cpu_wr(3'd0, 16'd20);
    cpu_wr(3'd4, 16'h0001);
    cpu_wr(3'd3, 16'h8001);
    go_to(9, 40);
    cpu_wr(3'd0, 16'd60);
    cpu_wr(3'd4, 16'hFFFF);
    cpu_wr(3'd3, 16'h0000);
    go_to(10, 80);
    cpu_wr(3'd0, 16'd0);
    go_to(12, 0);
    check(q.size() == 0, "R6 queue after reuse", q.size(), 0);

    // List-driven frame (R7 R8 R9 R10 R11)
    mem[8'h40] = {8'd3, 8'd24};  mem[8'h41] = {8'd6, 8'h5A};
    mem[8'h42] = 16'hFFFF;       mem[8'h43] = 16'h00FF;
    mem[8'h44] = 16'h0000;       mem[8'h45] = 16'hAAAA;
    mem[8'h46] = 16'h1234;       mem[8'h47] = 16'h8421;
    mem[8'h48] = {8'd8, 8'd50};  mem[8'h49] = {8'd10, 8'h00};
    mem[8'h4A] = 16'hF00F;       mem[8'h4B] = 16'h0FF0;
    mem[8'h4C] = 16'h8000;       mem[8'h4D] = 16'h0001;
    mem[8'h4E] = 16'h0000;       mem[8'h4F] = 16'h0000;
    mem[8'h50] = 16'h1111;       mem[8'h51] = 16'h2222;
    push_line(3, 24, 16'h00FF, 16'hFFFF, "R7");
    push_line(4, 24, 16'hAAAA, 16'h0000, "R8");
    push_line(5, 24, 16'h8421, 16'h1234, "R8");
    push_line(8, 50, 16'h0FF0, 16'hF00F, "R9");
    push_line(9, 50, 16'h0001, 16'h8000, "R9");
    go_to(20, 0);
    cpu_wr(3'd5, 16'h0040);
    cpu_wr(3'd6, 16'h0001);
    go_to(23, 0);
    acks = 0;
    addr_log.delete();
    go_to(22, 50);
    check(fetch_req == 1'b0, "R10 no request after end", int'(fetch_req), 0);
    cpu_wr(3'd6, 16'h0000);
    tick();
    check(acks == 16, "R10 words fetched", acks, 16);
    check(q.size() == 0, "R8 queue after frame", q.size(), 0);
    for (int i = 0; i < 16; i++) begin
      if (i < addr_log.size())
        check(addr_log[i] == 16'(16'h40 + i), "R11 address order", int'(addr_log[i]), 16'h40 + i);
    end
    check(idle_bad == 0, "R2 idle index", idle_bad, 0);
    summary();
  end
endmodule